// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one host command into the full run of byte operations that an SMBus transaction needs and hands them, one at a time, to a byte-level bus engine. That engine handles start conditions, bit timing, acknowledge sampling and stop conditions. Software loads the address, command and data registers, picks a transaction type and pulses start. The sequencer captures those values and drives the address phase, the optional command byte, a repeated start for reads that carry a command, the data bytes and an optional PEC byte. It then ends with a stop. Read results go back through write strobes into the data registers and into a block buffer.

Six transaction types are supported: quick, byte, byte-data, word-data, block, and an I2C-style block read. In the I2C-style block read, the command byte comes from data register 1, the direction bit held in the address register is ignored, and the byte count is set by software. The CRC value itself is computed outside the block. The sequencer only chooses when that value is sent or compared.

On completion, busy drops in the same cycle that a one-cycle interrupt pulse or device-error pulse appears. A device error is raised for an unsupported type, an illegal block count, a nack on any transmitted byte, or a PEC mismatch.

Top module: `smb_xact_seq`

## Requirements
- R1: `type_i` selects the transaction: 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block, 6 I2C block read. Types 4 (process call) and 7 are invalid. An invalid type makes no engine request, holds busy for one cycle and ends with `dev_err_o`.
- R2: Engine op codes on `eng_op_o` are 0 start+send, 1 send, 2 receive with ack, 3 receive with nack, 4 stop. Each request holds its op and byte until `eng_done_i`. A quick transaction is one start+send of `addr_i` unchanged, followed by a stop and `intr_o`.
- R3: A byte write sends the address, then `hcmd_i`, then stops. A byte read sends the address with bit 0 set, receives one byte with nack into data register 0, then stops.
- R4: A byte-data or word-data write sends address, command, data 0, and for word-data also data 1 (low byte first), then stops.
- R5: A byte-data or word-data read sends the address with bit 0 cleared, then the command, then a start+send of the address with bit 0 set. It then receives data 0 and, for word-data, data 1. The last byte is received with nack. The results are strobed into data registers 0 and 1.
- R6: A block write sends address, command and the count held in data register 0, then the count bytes read from the block buffer at indices 0 upward.
- R7: A block read receives the count first and writes it to data register 0. It then receives that many bytes into the block buffer at indices 0 upward, with the last one nacked. A received count of 0 or above MAX_BLK causes a stop followed by `dev_err_o`.
- R8: An I2C block read sends the address with bit 0 forced to 0 whatever was stored, then data register 1 as the command, then a start+send of the address with bit 0 set. It then receives the number of bytes given in data register 0. It never adds PEC.
- R9: With `pec_en_i` set, byte, byte-data, word-data and block transactions add one final byte. Writes send `pec_i` before the stop. Reads receive one more byte with nack and raise `dev_err_o` if it differs from `pec_i`.
- R10: A nack on any transmitted byte skips the rest of the transaction, issues a stop and ends with `dev_err_o`.
- R11: Busy falls in the same cycle that exactly one of `intr_o` or `dev_err_o` pulses for one cycle. Neither pulse occurs otherwise, and no engine request is made while idle.
- R12: Every data register and block buffer write strobe happens while busy is still high.
- R13: A start pulse while busy is ignored, and the register values captured at the accepted start are used throughout.
- R14: A block write or I2C block read whose data register 0 count is 0 or above MAX_BLK ends with `dev_err_o` and makes no engine request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only while idle |
| type_i | input | 3 | Transaction type (command encoding divided by four) |
| pec_en_i | input | 1 | Enable PEC byte |
| addr_i | input | 8 | Address register: address in 7:1, read flag in bit 0 |
| hcmd_i | input | 8 | Command register |
| dat0_i | input | 8 | Data register 0 (write data or block count) |
| dat1_i | input | 8 | Data register 1 (write data or I2C read command) |
| pec_i | input | 8 | Externally computed CRC value |
| busy_o | output | 1 | Transaction in progress |
| intr_o | output | 1 | One-cycle pulse on successful completion |
| dev_err_o | output | 1 | One-cycle pulse on failed completion |
| dat0_we_o | output | 1 | Write strobe for data register 0 |
| dat1_we_o | output | 1 | Write strobe for data register 1 |
| rdat_o | output | 8 | Received byte for data register writes |
| blk_idx_o | output | IDX_W | Block buffer index |
| blk_rdata_i | input | 8 | Block buffer byte at `blk_idx_o` |
| blk_we_o | output | 1 | Block buffer write strobe |
| blk_wdata_o | output | 8 | Block buffer write byte |
| eng_req_o | output | 1 | Engine request |
| eng_op_o | output | 3 | Engine op code |
| eng_byte_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Engine op finished (one cycle) |
| eng_ack_i | input | 1 | Acknowledge seen on a sent byte |
| eng_rbyte_i | input | 8 | Received byte |

## Verification
The assertions check the following on every cycle:
- an engine request keeps its op and byte steady until it is served;
- an invalid type stays off the engine and ends in an error two cycles later;
- completion pulses appear only on the falling edge of busy and never together;
- result strobes appear only while busy.

Only the directed scenarios can show the exact byte order of each transaction type. They also show the forced direction bit and the data register 1 command in the I2C read, the PEC append and compare, the nack cut-off, the block count limits, and that a second start is ignored.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [2:0] {
    OP_START_TX = 3'd0,
    OP_TX       = 3'd1,
    OP_RX_ACK   = 3'd2,
    OP_RX_NACK  = 3'd3,
    OP_STOP     = 3'd4
  } eng_op_e;

  typedef enum logic [2:0] {
    T_QUICK = 3'd0,
    T_BYTE  = 3'd1,
    T_BDATA = 3'd2,
    T_WORD  = 3'd3,
    T_PCALL = 3'd4,
    T_BLOCK = 3'd5,
    T_I2CRD = 3'd6,
    T_RSVD  = 3'd7
  } xact_e;

  typedef struct packed {
    logic       quick;
    logic       has_cmd;
    logic       rd;
    logic       rep;
    logic [1:0] nfix;
    logic       blk;
    logic       i2c;
    logic       pec;
  } plan_t;
endpackage

// File: rtl/smb_seq_decode.sv
module smb_seq_decode
  import smb_seq_pkg::*;
(
  input  logic [2:0] type_i,
  input  logic       rw_i,
  input  logic       pec_en_i,
  output logic       valid_o,
  output plan_t      plan_o
);
  always_comb begin
    plan_o  = '0;
    valid_o = 1'b1;
    unique case (xact_e'(type_i))
      T_QUICK: begin
        plan_o.quick = 1'b1;
        plan_o.rd    = rw_i;
      end
      T_BYTE: begin
        plan_o.rd      = rw_i;
        plan_o.has_cmd = !rw_i;
        plan_o.nfix    = rw_i ? 2'd1 : 2'd0;
        plan_o.pec     = pec_en_i;
      end
      T_BDATA, T_WORD: begin
        plan_o.rd      = rw_i;
        plan_o.has_cmd = 1'b1;
        plan_o.rep     = rw_i;
        plan_o.nfix    = (type_i == T_WORD) ? 2'd2 : 2'd1;
        plan_o.pec     = pec_en_i;
      end
      T_BLOCK: begin
        plan_o.rd      = rw_i;
        plan_o.has_cmd = 1'b1;
        plan_o.rep     = rw_i;
        plan_o.blk     = 1'b1;
        plan_o.pec     = pec_en_i;
      end
      T_I2CRD: begin
        plan_o.rd      = 1'b1;
        plan_o.has_cmd = 1'b1;
        plan_o.rep     = 1'b1;
        plan_o.blk     = 1'b1;
        plan_o.i2c     = 1'b1;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/smb_seq_idx.sv
module smb_seq_idx #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [7:0]       len_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = ({{(8-IDX_W){1'b0}}, idx_q} + 8'd1) == len_i;
endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
  import smb_seq_pkg::*;
#(
  parameter int MAX_BLK = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       valid_i,
  input  plan_t      plan_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] hcmd_i,
  input  logic [7:0] dat0_i,
  input  logic [7:0] dat1_i,
  input  logic [7:0] pec_i,
  input  logic       idx_last_i,
  output logic       idx_clr_o,
  output logic       idx_inc_o,
  output logic [7:0] len_o,
  input  logic [7:0] blk_rdata_i,
  output logic       busy_o,
  output logic       intr_o,
  output logic       dev_err_o,
  output logic       dat0_we_o,
  output logic       dat1_we_o,
  output logic       blk_we_o,
  output logic       eng_req_o,
  output eng_op_e    eng_op_o,
  output logic [7:0] eng_byte_o,
  input  logic       eng_done_i,
  input  logic       eng_ack_i,
  input  logic [7:0] eng_rbyte_i
);
  localparam logic [7:0] MAX_LEN = 8'(MAX_BLK);

  typedef enum logic [3:0] {
    S_IDLE, S_FAIL, S_ADDR, S_CMD, S_RADDR, S_TXCNT, S_TXBLK, S_TXD0,
    S_TXD1, S_TXPEC, S_RXD0, S_RXD1, S_RXCNT, S_RXBLK, S_RXPEC, S_STOP
  } state_e;

  state_e     st_q, st_d, tx_tail, rx_tail;
  plan_t      pl_q;
  logic [7:0] addr_q, cmd_q, d0_q, d1_q, len_q;
  logic       fail_q, fail_d, intr_q, err_q;
  logic       is_tx, bad_len_in, cnt_bad;

  assign is_tx = st_q inside {S_ADDR, S_CMD, S_RADDR, S_TXCNT, S_TXBLK,
                              S_TXD0, S_TXD1, S_TXPEC};
  assign tx_tail    = pl_q.pec ? S_TXPEC : S_STOP;
  assign rx_tail    = pl_q.pec ? S_RXPEC : S_STOP;
  assign bad_len_in = plan_i.blk && (!plan_i.rd || plan_i.i2c) &&
                      ((dat0_i == 8'd0) || (dat0_i > MAX_LEN));
  assign cnt_bad    = (eng_rbyte_i == 8'd0) || (eng_rbyte_i > MAX_LEN);

  // engine request decode
  always_comb begin
    eng_op_o   = OP_TX;
    eng_byte_o = '0;
    unique case (st_q)
      S_ADDR: begin
        eng_op_o   = OP_START_TX;
        eng_byte_o = pl_q.rep ? {addr_q[7:1], 1'b0} : addr_q;
      end
      S_CMD:   eng_byte_o = pl_q.i2c ? d1_q : cmd_q;
      S_RADDR: begin
        eng_op_o   = OP_START_TX;
        eng_byte_o = {addr_q[7:1], 1'b1};
      end
      S_TXCNT, S_TXD0: eng_byte_o = d0_q;
      S_TXBLK:         eng_byte_o = blk_rdata_i;
      S_TXD1:          eng_byte_o = d1_q;
      S_TXPEC:         eng_byte_o = pec_i;
      S_RXD0:  eng_op_o = (pl_q.nfix == 2'd1 && !pl_q.pec) ? OP_RX_NACK : OP_RX_ACK;
      S_RXD1:  eng_op_o = pl_q.pec ? OP_RX_ACK : OP_RX_NACK;
      S_RXCNT: eng_op_o = OP_RX_ACK;
      S_RXBLK: eng_op_o = (idx_last_i && !pl_q.pec) ? OP_RX_NACK : OP_RX_ACK;
      S_RXPEC: eng_op_o = OP_RX_NACK;
      S_STOP:  eng_op_o = OP_STOP;
      default: ;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    fail_d = fail_q;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        fail_d = !valid_i || bad_len_in;
        st_d   = fail_d ? S_FAIL : S_ADDR;
      end
      S_FAIL: st_d = S_IDLE;
      default: if (eng_done_i) begin
        if (is_tx && !eng_ack_i) begin
          st_d   = S_STOP;
          fail_d = 1'b1;
        end else begin
          unique case (st_q)
            S_ADDR:  st_d = pl_q.quick ? S_STOP : (pl_q.has_cmd ? S_CMD : S_RXD0);
            S_CMD:   st_d = pl_q.rep ? S_RADDR : pl_q.blk ? S_TXCNT :
                            (pl_q.nfix != 2'd0) ? S_TXD0 : tx_tail;
            S_RADDR: st_d = pl_q.i2c ? S_RXBLK : pl_q.blk ? S_RXCNT : S_RXD0;
            S_TXCNT: st_d = S_TXBLK;
            S_TXBLK: st_d = idx_last_i ? tx_tail : S_TXBLK;
            S_TXD0:  st_d = (pl_q.nfix == 2'd2) ? S_TXD1 : tx_tail;
            S_TXD1:  st_d = tx_tail;
            S_TXPEC: st_d = S_STOP;
            S_RXD0:  st_d = (pl_q.nfix == 2'd2) ? S_RXD1 : rx_tail;
            S_RXD1:  st_d = rx_tail;
            S_RXCNT: begin
              st_d = cnt_bad ? S_STOP : S_RXBLK;
              if (cnt_bad) fail_d = 1'b1;
            end
            S_RXBLK: st_d = idx_last_i ? rx_tail : S_RXBLK;
            S_RXPEC: begin
              st_d = S_STOP;
              if (eng_rbyte_i != pec_i) fail_d = 1'b1;
            end
            S_STOP:  st_d = S_IDLE;
            default: st_d = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pl_q   <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      len_q  <= '0;
      fail_q <= 1'b0;
      intr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fail_q <= fail_d;
      intr_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == S_IDLE && start_i) begin
        pl_q   <= plan_i;
        addr_q <= addr_i;
        cmd_q  <= hcmd_i;
        d0_q   <= dat0_i;
        d1_q   <= dat1_i;
        len_q  <= dat0_i;
      end
      if (st_q == S_RXCNT && eng_done_i) len_q <= eng_rbyte_i;
      if (st_q != S_IDLE && st_d == S_IDLE) begin
        if (fail_d) err_q  <= 1'b1;
        else        intr_q <= 1'b1;
      end
    end
  end

  assign busy_o    = st_q != S_IDLE;
  assign intr_o    = intr_q;
  assign dev_err_o = err_q;
  assign eng_req_o = !(st_q inside {S_IDLE, S_FAIL});
  assign len_o     = len_q;
  assign idx_clr_o = !(st_q inside {S_TXBLK, S_RXBLK});
  assign idx_inc_o = eng_done_i && (st_q inside {S_TXBLK, S_RXBLK});
  assign dat0_we_o = eng_done_i && (st_q inside {S_RXD0, S_RXCNT});
  assign dat1_we_o = eng_done_i && (st_q == S_RXD1);
  assign blk_we_o  = eng_done_i && (st_q == S_RXBLK);
endmodule

// File: rtl/smb_xact_seq.sv
module smb_xact_seq
  import smb_seq_pkg::*;
#(
  parameter  int MAX_BLK = 32,
  localparam int IDX_W   = $clog2(MAX_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       type_i,
  input  logic             pec_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       hcmd_i,
  input  logic [7:0]       dat0_i,
  input  logic [7:0]       dat1_i,
  input  logic [7:0]       pec_i,
  output logic             busy_o,
  output logic             intr_o,
  output logic             dev_err_o,
  output logic             dat0_we_o,
  output logic             dat1_we_o,
  output logic [7:0]       rdat_o,
  output logic [IDX_W-1:0] blk_idx_o,
  input  logic [7:0]       blk_rdata_i,
  output logic             blk_we_o,
  output logic [7:0]       blk_wdata_o,
  output logic             eng_req_o,
  output logic [2:0]       eng_op_o,
  output logic [7:0]       eng_byte_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rbyte_i
);
  plan_t      plan;
  logic       valid, idx_clr, idx_inc, idx_last;
  logic [7:0] len;
  eng_op_e    op;

  smb_seq_decode i_decode (
    .type_i   (type_i),
    .rw_i     (addr_i[0]),
    .pec_en_i (pec_en_i),
    .valid_o  (valid),
    .plan_o   (plan)
  );

  smb_seq_idx #(.IDX_W(IDX_W)) i_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (idx_clr),
    .inc_i  (idx_inc),
    .len_i  (len),
    .idx_o  (blk_idx_o),
    .last_o (idx_last)
  );

  smb_seq_fsm #(.MAX_BLK(MAX_BLK)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .valid_i     (valid),
    .plan_i      (plan),
    .addr_i      (addr_i),
    .hcmd_i      (hcmd_i),
    .dat0_i      (dat0_i),
    .dat1_i      (dat1_i),
    .pec_i       (pec_i),
    .idx_last_i  (idx_last),
    .idx_clr_o   (idx_clr),
    .idx_inc_o   (idx_inc),
    .len_o       (len),
    .blk_rdata_i (blk_rdata_i),
    .busy_o      (busy_o),
    .intr_o      (intr_o),
    .dev_err_o   (dev_err_o),
    .dat0_we_o   (dat0_we_o),
    .dat1_we_o   (dat1_we_o),
    .blk_we_o    (blk_we_o),
    .eng_req_o   (eng_req_o),
    .eng_op_o    (op),
    .eng_byte_o  (eng_byte_o),
    .eng_done_i  (eng_done_i),
    .eng_ack_i   (eng_ack_i),
    .eng_rbyte_i (eng_rbyte_i)
  );

  assign eng_op_o    = op;
  assign rdat_o      = eng_rbyte_i;
  assign blk_wdata_o = eng_rbyte_i;
endmodule

// File: rtl/smb_seq_chk.sv
module smb_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] type_i,
  input logic       busy_o,
  input logic       intr_o,
  input logic       dev_err_o,
  input logic       dat0_we_o,
  input logic       dat1_we_o,
  input logic       blk_we_o,
  input logic       eng_req_o,
  input logic [2:0] eng_op_o,
  input logic [7:0] eng_byte_o,
  input logic       eng_done_i
);
  p_bad_type_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (type_i == 3'd4 || type_i == 3'd7) |=> busy_o && !eng_req_o);

  p_bad_type_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (type_i == 3'd4 || type_i == 3'd7) |=> ##1 dev_err_o);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_byte_o));

  p_one_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intr_o && dev_err_o));

  p_flag_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_o || dev_err_o) |-> !busy_o && $past(busy_o));

  p_fall_has_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (intr_o || dev_err_o));

  p_idle_no_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !eng_req_o);

  p_results_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat0_we_o || dat1_we_o || blk_we_o) |-> busy_o);
endmodule

bind smb_xact_seq smb_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .type_i     (type_i),
  .busy_o     (busy_o),
  .intr_o     (intr_o),
  .dev_err_o  (dev_err_o),
  .dat0_we_o  (dat0_we_o),
  .dat1_we_o  (dat1_we_o),
  .blk_we_o   (blk_we_o),
  .eng_req_o  (eng_req_o),
  .eng_op_o   (eng_op_o),
  .eng_byte_o (eng_byte_o),
  .eng_done_i (eng_done_i)
);

// File: tb/test_smb_xact_seq.sv
module test_smb_xact_seq;
  import smb_seq_pkg::*;
  localparam int MAX_BLK = 32;
  localparam int IDX_W   = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, pec_en_i = 1'b0;
  logic [2:0] type_i = '0;
  logic [7:0] addr_i = '0, hcmd_i = '0, dat0_i = '0, dat1_i = '0, pec_i = '0;
  logic busy_o, intr_o, dev_err_o, dat0_we_o, dat1_we_o, blk_we_o, eng_req_o;
  logic [7:0] rdat_o, blk_wdata_o, eng_byte_o, blk_rdata_i;
  logic [IDX_W-1:0] blk_idx_o;
  logic [2:0] eng_op_o;
  logic eng_done_i = 1'b0, eng_ack_i = 1'b0;
  logic [7:0] eng_rbyte_i = '0;

  logic [7:0] blk_src [0:MAX_BLK-1];
  logic [7:0] bm      [0:MAX_BLK-1];
  logic [7:0] rx_q    [0:15];
  logic [10:0] lg     [0:79];
  logic [10:0] ex_q   [0:15];
  logic [7:0] d0_cap, d1_cap;
  int n_log = 0, tx_cnt = 0, rx_i = 0, nack_at = -1, ex_n = 0;
  int n_intr = 0, n_err = 0, got_intr = 0, got_err = 0, idle_wr = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;
  assign blk_rdata_i = blk_src[blk_idx_o];

  smb_xact_seq #(.MAX_BLK(MAX_BLK)) i_smb_xact_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .type_i(type_i),
    .pec_en_i(pec_en_i), .addr_i(addr_i), .hcmd_i(hcmd_i), .dat0_i(dat0_i),
    .dat1_i(dat1_i), .pec_i(pec_i), .busy_o(busy_o), .intr_o(intr_o),
    .dev_err_o(dev_err_o), .dat0_we_o(dat0_we_o), .dat1_we_o(dat1_we_o),
    .rdat_o(rdat_o), .blk_idx_o(blk_idx_o), .blk_rdata_i(blk_rdata_i),
    .blk_we_o(blk_we_o), .blk_wdata_o(blk_wdata_o), .eng_req_o(eng_req_o),
    .eng_op_o(eng_op_o), .eng_byte_o(eng_byte_o), .eng_done_i(eng_done_i),
    .eng_ack_i(eng_ack_i), .eng_rbyte_i(eng_rbyte_i)
  );

  // byte engine model: records each request, answers one cycle later
  initial begin
    forever begin
      @(negedge clk_i);
      eng_done_i = 1'b0;
      if (rst_ni && eng_req_o) begin
        if (n_log < 80) lg[n_log] = {eng_op_o, eng_byte_o};
        n_log++;
        @(negedge clk_i);
        if (eng_op_o == OP_START_TX || eng_op_o == OP_TX) begin
          eng_ack_i = (tx_cnt != nack_at);
          tx_cnt++;
        end else if (eng_op_o == OP_RX_ACK || eng_op_o == OP_RX_NACK) begin
          eng_rbyte_i = rx_q[rx_i];
          rx_i++;
        end
        eng_done_i = 1'b1;
        #1;
        if ((dat0_we_o || dat1_we_o || blk_we_o) && !busy_o) idle_wr++;
        if (dat0_we_o) d0_cap = rdat_o;
        if (dat1_we_o) d1_cap = rdat_o;
        if (blk_we_o) bm[blk_idx_o] = blk_wdata_o;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      #3;
      if (intr_o)    n_intr++;
      if (dev_err_o) n_err++;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] b);
    ex_q[ex_n] = {op, b};
    ex_n++;
  endtask

  task automatic check_seq(input string req);
    chk(n_log == ex_n, req, "op count", n_log, ex_n);
    for (int i = 0; i < ex_n && i < n_log; i++)
      chk(lg[i] == ex_q[i], req, $sformatf("op %0d {op,byte}", i), lg[i], ex_q[i]);
  endtask

  task automatic run(input logic [2:0] t, input logic pe, input logic [7:0] a,
                     input logic [7:0] c, input logic [7:0] d0, input logic [7:0] d1);
    int i0, e0, w;
    @(negedge clk_i);
    type_i = t; pec_en_i = pe; addr_i = a; hcmd_i = c; dat0_i = d0; dat1_i = d1;
    n_log = 0; tx_cnt = 0; rx_i = 0;
    i0 = n_intr; e0 = n_err;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    w = 0;
    while (n_intr == i0 && n_err == e0 && w < 3000) begin
      @(negedge clk_i);
      w++;
    end
    repeat (2) @(negedge clk_i);
    got_intr = n_intr - i0;
    got_err  = n_err - e0;
    nack_at  = -1;
    ex_n     = 0;
  endtask

  task automatic done_chk(input string req, input bit exp_err);
    chk(got_intr == (exp_err ? 0 : 1), req, "intr pulses", got_intr, exp_err ? 0 : 1);
    chk(got_err == (exp_err ? 1 : 0), req, "error pulses", got_err, exp_err ? 1 : 0);
    chk(busy_o == 1'b0, "R11", "busy after completion", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0 && eng_req_o == 1'b0, "R11", "reset busy/req", {busy_o, eng_req_o}, 0);
    chk(intr_o == 1'b0 && dev_err_o == 1'b0, "R11", "reset flags", {intr_o, dev_err_o}, 0);
  endtask

  task automatic t_bad_type();
    run(3'd4, 1'b0, 8'h50, 8'h01, 8'h00, 8'h00);
    chk(n_log == 0, "R1", "process call engine ops", n_log, 0);
    done_chk("R1", 1'b1);
    run(3'd7, 1'b0, 8'h50, 8'h01, 8'h00, 8'h00);
    chk(n_log == 0, "R1", "reserved type engine ops", n_log, 0);
    done_chk("R1", 1'b1);
  endtask

  task automatic t_quick();
    run(3'd0, 1'b0, 8'hA1, 8'h00, 8'h00, 8'h00);
    ex(OP_START_TX, 8'hA1); ex(OP_STOP, 8'h00);
    check_seq("R2");
    done_chk("R2", 1'b0);
  endtask

  task automatic t_byte();
    run(3'd1, 1'b0, 8'h50, 8'h3C, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h50); ex(OP_TX, 8'h3C); ex(OP_STOP, 8'h00);
    check_seq("R3");
    done_chk("R3", 1'b0);
    rx_q[0] = 8'h77;
    d0_cap = 8'h00;
    run(3'd1, 1'b0, 8'h51, 8'h00, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h51); ex(OP_RX_NACK, 8'h00); ex(OP_STOP, 8'h00);
    check_seq("R3");
    chk(d0_cap == 8'h77, "R3", "byte read data0", d0_cap, 8'h77);
    done_chk("R3", 1'b0);
  endtask

  task automatic t_word_wr();
    run(3'd3, 1'b0, 8'h40, 8'h12, 8'hAB, 8'hCD);
    ex(OP_START_TX, 8'h40); ex(OP_TX, 8'h12); ex(OP_TX, 8'hAB); ex(OP_TX, 8'hCD);
    ex(OP_STOP, 8'h00);
    check_seq("R4");
    done_chk("R4", 1'b0);
  endtask

  task automatic t_word_rd();
    rx_q[0] = 8'h34; rx_q[1] = 8'h56;
    run(3'd3, 1'b0, 8'h41, 8'h22, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h40); ex(OP_TX, 8'h22); ex(OP_START_TX, 8'h41);
    ex(OP_RX_ACK, 8'h00); ex(OP_RX_NACK, 8'h00); ex(OP_STOP, 8'h00);
    check_seq("R5");
    chk(d0_cap == 8'h34, "R5", "word low byte", d0_cap, 8'h34);
    chk(d1_cap == 8'h56, "R5", "word high byte", d1_cap, 8'h56);
    chk(idle_wr == 0, "R12", "writes after busy fell", idle_wr, 0);
    done_chk("R5", 1'b0);
  endtask

  task automatic t_blk_wr();
    blk_src[0] = 8'h11; blk_src[1] = 8'h22; blk_src[2] = 8'h33;
    run(3'd5, 1'b0, 8'h30, 8'h05, 8'h03, 8'h00);
    ex(OP_START_TX, 8'h30); ex(OP_TX, 8'h05); ex(OP_TX, 8'h03);
    ex(OP_TX, 8'h11); ex(OP_TX, 8'h22); ex(OP_TX, 8'h33); ex(OP_STOP, 8'h00);
    check_seq("R6");
    done_chk("R6", 1'b0);
  endtask

  task automatic t_blk_rd();
    rx_q[0] = 8'h02; rx_q[1] = 8'h9A; rx_q[2] = 8'h9B;
    run(3'd5, 1'b0, 8'h31, 8'h06, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h30); ex(OP_TX, 8'h06); ex(OP_START_TX, 8'h31);
    ex(OP_RX_ACK, 8'h00); ex(OP_RX_ACK, 8'h00); ex(OP_RX_NACK, 8'h00);
    ex(OP_STOP, 8'h00);
    check_seq("R7");
    chk(d0_cap == 8'h02, "R7", "block count in data0", d0_cap, 2);
    chk(bm[0] == 8'h9A && bm[1] == 8'h9B, "R7", "block buffer", {bm[0], bm[1]}, 16'h9A9B);
    done_chk("R7", 1'b0);
    rx_q[0] = 8'h00;
    run(3'd5, 1'b0, 8'h31, 8'h06, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h30); ex(OP_TX, 8'h06); ex(OP_START_TX, 8'h31);
    ex(OP_RX_ACK, 8'h00); ex(OP_STOP, 8'h00);
    check_seq("R7");
    done_chk("R7", 1'b1);
  endtask

  task automatic t_i2c_rd();
    rx_q[0] = 8'hC1; rx_q[1] = 8'hC2;
    run(3'd6, 1'b1, 8'h63, 8'hEE, 8'h02, 8'h44);
    ex(OP_START_TX, 8'h62); ex(OP_TX, 8'h44); ex(OP_START_TX, 8'h63);
    ex(OP_RX_ACK, 8'h00); ex(OP_RX_NACK, 8'h00); ex(OP_STOP, 8'h00);
    check_seq("R8");
    chk(bm[0] == 8'hC1 && bm[1] == 8'hC2, "R8", "i2c block data", {bm[0], bm[1]}, 16'hC1C2);
    done_chk("R8", 1'b0);
  endtask

  task automatic t_pec();
    pec_i = 8'h5A;
    run(3'd2, 1'b1, 8'h20, 8'h07, 8'h99, 8'h00);
    ex(OP_START_TX, 8'h20); ex(OP_TX, 8'h07); ex(OP_TX, 8'h99); ex(OP_TX, 8'h5A);
    ex(OP_STOP, 8'h00);
    check_seq("R9");
    done_chk("R9", 1'b0);
    rx_q[0] = 8'h10; rx_q[1] = 8'h5A;
    run(3'd2, 1'b1, 8'h21, 8'h07, 8'h00, 8'h00);
    ex(OP_START_TX, 8'h20); ex(OP_TX, 8'h07); ex(OP_START_TX, 8'h21);
    ex(OP_RX_ACK, 8'h00); ex(OP_RX_NACK, 8'h00); ex(OP_STOP, 8'h00);
    check_seq("R9");
    chk(d0_cap == 8'h10, "R9", "data before PEC", d0_cap, 8'h10);
    done_chk("R9", 1'b0);
    rx_q[0] = 8'h10; rx_q[1] = 8'h5B;
    run(3'd2, 1'b1, 8'h21, 8'h07, 8'h00, 8'h00);
    done_chk("R9", 1'b1);
  endtask

  task automatic t_nack();
    nack_at = 1;
    run(3'd2, 1'b0, 8'h20, 8'h07, 8'h99, 8'h00);
    ex(OP_START_TX, 8'h20); ex(OP_TX, 8'h07); ex(OP_STOP, 8'h00);
    check_seq("R10");
    done_chk("R10", 1'b1);
    nack_at = 0;
    run(3'd3, 1'b0, 8'h22, 8'h07, 8'h99, 8'h00);
    ex(OP_START_TX, 8'h22); ex(OP_STOP, 8'h00);
    check_seq("R10");
    done_chk("R10", 1'b1);
  endtask

  task automatic t_start_busy();
    int i0, w;
    @(negedge clk_i);
    type_i = 3'd3; pec_en_i = 1'b0; addr_i = 8'h40; hcmd_i = 8'h12;
    dat0_i = 8'hAB; dat1_i = 8'hCD;
    n_log = 0; tx_cnt = 0; rx_i = 0; i0 = n_intr + n_err;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    type_i = 3'd0; addr_i = 8'h99; dat0_i = 8'h00;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    w = 0;
    while (n_intr + n_err == i0 && w < 3000) begin
      @(negedge clk_i);
      w++;
    end
    repeat (20) @(negedge clk_i);
    ex_n = 0;
    ex(OP_START_TX, 8'h40); ex(OP_TX, 8'h12); ex(OP_TX, 8'hAB); ex(OP_TX, 8'hCD);
    ex(OP_STOP, 8'h00);
    check_seq("R13");
    chk(n_intr + n_err - i0 == 1, "R13", "completions", n_intr + n_err - i0, 1);
    ex_n = 0;
  endtask

  task automatic t_blk_len();
    run(3'd5, 1'b0, 8'h30, 8'h05, 8'h00, 8'h00);
    chk(n_log == 0, "R14", "zero count engine ops", n_log, 0);
    done_chk("R14", 1'b1);
    run(3'd6, 1'b0, 8'h30, 8'h05, 8'd33, 8'h00);
    chk(n_log == 0, "R14", "oversize count engine ops", n_log, 0);
    done_chk("R14", 1'b1);
  endtask

  initial begin
    for (int i = 0; i < MAX_BLK; i++) begin
      blk_src[i] = 8'(i);
      bm[i] = 8'h00;
    end
    for (int i = 0; i < 16; i++) rx_q[i] = 8'h00;
    d0_cap = 8'h00;
    d1_cap = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_bad_type();
    t_quick();
    t_byte();
    t_word_wr();
    t_word_rd();
    t_blk_wr();
    t_blk_rd();
    t_i2c_rd();
    t_pec();
    t_nack();
    t_start_busy();
    t_blk_len();
    summary();
    $finish;
  end
endmodule